// File: doc/BRIEF.md
# NOR Flash Read-Mode and Query Controller

This block is the read-mode part of a NOR-flash command state machine. It takes qualified write strobes, each with a word address and a command byte. From them it tracks which of three read modes the part is in: plain array read, identification mode, or the standardized query mode. The read path is combinational. In array mode it passes the external array word through. In identification mode it returns the maker and device codes. In query mode it returns words from a small fixed query table that opens with the ASCII signature "QRY".

A single write of 98h to word address 055h switches to query mode, from array read or from identification mode. Query mode then holds until a reset command (F0h) arrives. Identification mode is reached by a three-cycle unlock sequence. A forced-reset input models supply lockout or power-up and returns everything to array read. A busy input keeps the controller from entering query mode while an embedded operation runs. Program and erase are not part of this block.

Top module: `nor_query_ctrl`

## Requirements
- R1: After rst_n or at power-up the mode output is 0 (array read), and rd_data equals array_data for every rd_addr, including 010h. The mode encoding is 0 for array read, 1 for identification and 2 for query.
- R2: In array mode, a write of 98h to word address 055h exactly sets mode to 2 from the next clock. A 98h write to any other address (for example 054h or 155h) leaves mode at 0.
- R3: In identification mode, a write of 98h to word address 055h sets mode to 2 from the next clock.
- R4: Query mode persists across any number of reads and across every write whose data is not F0h, including unlock bytes and repeated 98h@055h.
- R5: A write of F0h to any address returns the mode to 0 from any mode.
- R6: In query mode, reads at 010h, 011h and 012h return 0051h, 0052h and 0059h.
- R7: In query mode, 013h returns 0002h, 015h returns 0040h, and 014h, 016h, 017h, 018h, 019h and 01Ah return 0000h.
- R8: In query mode, every address outside 010h..01Ah returns 0000h.
- R9: In array mode, the writes AAh@555h, 55h@2AAh, 90h@555h in that order set mode to 1. In mode 1, address 000h returns the maker code 0001h, address 001h returns the device code 227Eh, and other addresses return 0000h.
- R10: A write that does not match the next expected unlock cycle returns the tracker to idle, so the mode stays 0. A complete sequence that follows still sets mode 1.
- R11: While busy is 1, a 98h@055h write is ignored and the mode keeps its value.
- R12: Asserting force_rst for one clock returns the mode to 0 from query or identification mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_rst | input | 1 | Synchronous forced return to array read (supply lockout or power-up) |
| busy | input | 1 | Embedded operation in progress; blocks query entry |
| wr_en | input | 1 | Qualified write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W (12) | Word address of the write |
| wr_data | input | 8 | Command byte of the write |
| rd_addr | input | ADDR_W (12) | Word address of the read |
| array_data | input | RD_W (16) | Word read from the external array |
| rd_data | output | RD_W (16) | Steered read word |
| mode | output | 2 | Current read mode (0 array, 1 identification, 2 query) |

## Verification
The hardest situations to reach are the partial unlock sequences. The tracker is invisible at the ports and shows itself only when a later 90h either does or does not change the mode. The stimulus therefore breaks the sequence at each stage, with a wrong data byte, a wrong address, or a skipped cycle. Each time it sends the remaining cycles and checks that the mode stays 0, then shows that a clean sequence still works. Query persistence and the busy block are shown the same way: writes that could disturb the mode are followed by table reads and mode checks before any reset command is sent.

// File: rtl/nqc_pkg.sv
package nqc_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_QUERY = 2'd2
  } mode_t;

  localparam logic [CMD_W-1:0] CMD_RESET  = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_QUERY  = 8'h98;
  localparam logic [CMD_W-1:0] CMD_UNLK1  = 8'hAA;
  localparam logic [CMD_W-1:0] CMD_UNLK2  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_IDENT  = 8'h90;

  localparam int unsigned QUERY_ADDR = 32'h055;
  localparam int unsigned UNLK_ADDR1 = 32'h555;
  localparam int unsigned UNLK_ADDR2 = 32'h2AA;

  // Query table word for a word address; zero outside the table.
  function automatic logic [15:0] query_word(input int unsigned a);
    logic [15:0] w;
    case (a)
      32'h10:  w = 16'h0051;
      32'h11:  w = 16'h0052;
      32'h12:  w = 16'h0059;
      32'h13:  w = 16'h0002;
      32'h15:  w = 16'h0040;
      default: w = 16'h0000;
    endcase
    return w;
  endfunction

  // Identification word: maker code at 0, device code at 1.
  function automatic logic [15:0] ident_word(input int unsigned a,
                                             input logic [15:0] maker,
                                             input logic [15:0] device);
    logic [15:0] w;
    case (a)
      32'h0:   w = maker;
      32'h1:   w = device;
      default: w = 16'h0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/nqc_unlock.sv
module nqc_unlock
  import nqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  output logic              unlock_done
);

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_ONE  = 2'd1,
    TRK_TWO  = 2'd2
  } trk_t;

  trk_t trk_q, trk_d;

  logic hit1, hit2, hit3;
  assign hit1 = (32'(wr_addr) == UNLK_ADDR1) && (wr_data == CMD_UNLK1);
  assign hit2 = (32'(wr_addr) == UNLK_ADDR2) && (wr_data == CMD_UNLK2);
  assign hit3 = (32'(wr_addr) == UNLK_ADDR1) && (wr_data == CMD_IDENT);

  assign unlock_done = step_en && (trk_q == TRK_TWO) && hit3;

  always_comb begin
    trk_d = trk_q;
    if (clr) begin
      trk_d = TRK_IDLE;
    end else if (step_en) begin
      case (trk_q)
        TRK_IDLE: trk_d = hit1 ? TRK_ONE : TRK_IDLE;
        TRK_ONE:  trk_d = hit2 ? TRK_TWO : TRK_IDLE;
        default:  trk_d = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk_q <= TRK_IDLE;
    else        trk_q <= trk_d;
  end

endmodule

// File: rtl/nqc_mode_fsm.sv
module nqc_mode_fsm
  import nqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  force_rst,
  input  logic  cmd_reset,
  input  logic  cmd_query,
  input  logic  unlock_done,
  output mode_t mode_q
);

  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (force_rst || cmd_reset) mode_d = MODE_ARRAY;
    else if (cmd_query)         mode_d = MODE_QUERY;
    else if (unlock_done)       mode_d = MODE_IDENT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ARRAY;
    else        mode_q <= mode_d;
  end

endmodule

// File: rtl/nqc_read_mux.sv
module nqc_read_mux
  import nqc_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          RD_W   = 16,
  parameter logic [15:0] MAKER  = 16'h0001,
  parameter logic [15:0] DEVICE = 16'h227E
) (
  input  mode_t             mode_q,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [RD_W-1:0]   array_data,
  output logic [RD_W-1:0]   rd_data
);

  logic [15:0] tbl_q, tbl_i;
  assign tbl_q = query_word(32'(rd_addr));
  assign tbl_i = ident_word(32'(rd_addr), MAKER, DEVICE);

  always_comb begin
    case (mode_q)
      MODE_QUERY: rd_data = RD_W'(tbl_q);
      MODE_IDENT: rd_data = RD_W'(tbl_i);
      default:    rd_data = array_data;
    endcase
  end

endmodule

// File: rtl/nor_query_ctrl.sv
module nor_query_ctrl
  import nqc_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          RD_W   = 16,
  parameter logic [15:0] MAKER  = 16'h0001,
  parameter logic [15:0] DEVICE = 16'h227E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_rst,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [RD_W-1:0]   array_data,
  output logic [RD_W-1:0]   rd_data,
  output logic [1:0]        mode
);

  mode_t mode_q;

  // Decoded command events, brought out for the checker.
  logic cmd_reset, cmd_query, unlock_done, step_en, trk_clr;

  assign cmd_reset = wr_en && (wr_data == CMD_RESET);
  assign cmd_query = wr_en && !busy && (mode_q != MODE_QUERY) &&
                     (wr_data == CMD_QUERY) && (32'(wr_addr) == QUERY_ADDR);
  assign step_en   = wr_en && (mode_q == MODE_ARRAY) && !cmd_reset && !cmd_query;
  assign trk_clr   = force_rst || cmd_reset || cmd_query;

  nqc_unlock #(.ADDR_W(ADDR_W)) u_unlock (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (trk_clr),
    .step_en     (step_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .unlock_done (unlock_done)
  );

  nqc_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_rst   (force_rst),
    .cmd_reset   (cmd_reset),
    .cmd_query   (cmd_query),
    .unlock_done (unlock_done),
    .mode_q      (mode_q)
  );

  nqc_read_mux #(
    .ADDR_W (ADDR_W),
    .RD_W   (RD_W),
    .MAKER  (MAKER),
    .DEVICE (DEVICE)
  ) u_mux (
    .mode_q     (mode_q),
    .rd_addr    (rd_addr),
    .array_data (array_data),
    .rd_data    (rd_data)
  );

  assign mode = mode_q;

endmodule

// File: rtl/nqc_checker.sv
module nqc_checker #(
  parameter int ADDR_W = 12,
  parameter int RD_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              force_rst,
  input logic              busy,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [RD_W-1:0]   array_data,
  input logic [RD_W-1:0]   rd_data,
  input logic [1:0]        mode,
  input logic              unlock_done
);

  logic qry_write;
  assign qry_write = wr_en && (wr_data == 8'h98) && (32'(wr_addr) == 32'h055);

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  assert_array_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (rd_data == array_data));

  assert_query_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_write && !busy && !force_rst && mode != 2'd2) |=> (mode == 2'd2));

  assert_query_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !force_rst && !(wr_en && wr_data == 8'hF0)) |=> (mode == 2'd2));

  assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hF0) |=> (mode == 2'd0));

  assert_ident_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_done && !force_rst) |=> (mode == 2'd1));

  assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode != 2'd2) |=> (mode != 2'd2));

  assert_force_R12: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> (mode == 2'd0));

endmodule

bind nor_query_ctrl nqc_checker #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_nqc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .force_rst   (force_rst),
  .busy        (busy),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .array_data  (array_data),
  .rd_data     (rd_data),
  .mode        (mode),
  .unlock_done (unlock_done)
);

// File: tb/test_nor_query_ctrl.sv
`timescale 1ns/1ps
module test_nor_query_ctrl;

  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          force_rst = 1'b0;
  logic          busy = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] array_data;
  logic [DW-1:0] rd_data;
  logic [1:0]    mode;

  always #2.5 clk = ~clk;

  // Array model: a word pattern derived from the read address.
  function automatic logic [15:0] arr_word(input logic [AW-1:0] a);
    return 16'hA000 ^ {4'h0, a};
  endfunction
  assign array_data = arr_word(rd_addr);

  nor_query_ctrl i_nor_query_ctrl (
    .clk(clk), .rst_n(rst_n), .force_rst(force_rst), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .array_data(array_data),
    .rd_data(rd_data), .mode(mode)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [15:0] q_data[$];
  logic [1:0]  q_mode[$];
  string       q_tag[$];

  // Expected query table written from the requirement text.
  function automatic logic [15:0] exp_query(input logic [AW-1:0] a);
    if (a == 12'h010) return 16'h0051;
    if (a == 12'h011) return 16'h0052;
    if (a == 12'h012) return 16'h0059;
    if (a == 12'h013) return 16'h0002;
    if (a == 12'h015) return 16'h0040;
    return 16'h0000;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_force();
    @(negedge clk);
    force_rst = 1'b1;
    @(negedge clk);
    force_rst = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [1:0] m, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    rd_addr = a;
    q_data.push_back(d);
    q_mode.push_back(m);
    q_tag.push_back(tag);
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
    wr(12'h555, 8'h90);
  endtask

  // Monitor: compares one item shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_data.size() > 0) begin
        logic [15:0] ed;
        logic [1:0]  em;
        string       et;
        ed = q_data.pop_front();
        em = q_mode.pop_front();
        et = q_tag.pop_front();
        vectors++;
        if (rd_data !== ed || mode !== em) begin
          miscompares++;
          $display("FAIL %s: rd_data=%h mode=%0d expected rd_data=%h mode=%0d",
                   et, rd_data, mode, ed, em);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, arr_word(12'h000), 2'd0, "R1");
    rd(12'h010, arr_word(12'h010), 2'd0, "R1");

    // R2 wrong addresses do not enter
    wr(12'h054, 8'h98);
    rd(12'h010, arr_word(12'h010), 2'd0, "R2");
    wr(12'h155, 8'h98);
    rd(12'h011, arr_word(12'h011), 2'd0, "R2");

    // R2 entry from array
    wr(12'h055, 8'h98);
    rd(12'h010, 16'h0051, 2'd2, "R2");
    // R6 signature
    rd(12'h010, exp_query(12'h010), 2'd2, "R6");
    rd(12'h011, exp_query(12'h011), 2'd2, "R6");
    rd(12'h012, exp_query(12'h012), 2'd2, "R6");
    // R7 remainder of the table
    for (int a = 12'h013; a <= 12'h01A; a++)
      rd(AW'(a), exp_query(AW'(a)), 2'd2, "R7");
    // R8 outside the table
    rd(12'h000, 16'h0000, 2'd2, "R8");
    rd(12'h00F, 16'h0000, 2'd2, "R8");
    rd(12'h01B, 16'h0000, 2'd2, "R8");
    rd(12'h555, 16'h0000, 2'd2, "R8");
    rd(12'hFFF, 16'h0000, 2'd2, "R8");

    // R4 persistence across non-reset writes
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
    wr(12'h555, 8'h90);
    rd(12'h012, 16'h0059, 2'd2, "R4");
    wr(12'h055, 8'h98);
    wr(12'h000, 8'h00);
    rd(12'h010, 16'h0051, 2'd2, "R4");
    rd(12'h013, 16'h0002, 2'd2, "R4");

    // R5 reset command from query, odd address
    wr(12'h123, 8'hF0);
    rd(12'h010, arr_word(12'h010), 2'd0, "R5");

    // R9 identification
    unlock();
    rd(12'h000, 16'h0001, 2'd1, "R9");
    rd(12'h001, 16'h227E, 2'd1, "R9");
    rd(12'h002, 16'h0000, 2'd1, "R9");
    rd(12'h010, 16'h0000, 2'd1, "R9");

    // R3 query from identification
    wr(12'h055, 8'h98);
    rd(12'h011, 16'h0052, 2'd2, "R3");
    wr(12'h000, 8'hF0);
    rd(12'h001, arr_word(12'h001), 2'd0, "R5");

    // R5 reset from identification
    unlock();
    rd(12'h001, 16'h227E, 2'd1, "R9");
    wr(12'h7FF, 8'hF0);
    rd(12'h001, arr_word(12'h001), 2'd0, "R5");

    // R10 broken sequences
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h123, 8'h00); wr(12'h555, 8'h90);
    rd(12'h000, arr_word(12'h000), 2'd0, "R10");
    wr(12'h555, 8'hAA); wr(12'h555, 8'h90);
    rd(12'h000, arr_word(12'h000), 2'd0, "R10");
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'h90);
    rd(12'h000, arr_word(12'h000), 2'd0, "R10");
    wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    rd(12'h000, arr_word(12'h000), 2'd0, "R10");
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h554, 8'h90);
    rd(12'h000, arr_word(12'h000), 2'd0, "R10");
    unlock();
    rd(12'h000, 16'h0001, 2'd1, "R10");
    wr(12'h000, 8'hF0);

    // R11 busy blocks entry
    busy = 1'b1;
    wr(12'h055, 8'h98);
    rd(12'h010, arr_word(12'h010), 2'd0, "R11");
    unlock();
    wr(12'h055, 8'h98);
    rd(12'h000, 16'h0001, 2'd1, "R11");
    busy = 1'b0;
    wr(12'h055, 8'h98);
    rd(12'h010, 16'h0051, 2'd2, "R11");

    // R12 forced reset
    pulse_force();
    rd(12'h010, arr_word(12'h010), 2'd0, "R12");
    unlock();
    rd(12'h001, 16'h227E, 2'd1, "R12");
    pulse_force();
    rd(12'h001, arr_word(12'h001), 2'd0, "R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule